// File: doc/BRIEF.md
# Three-wire converter read controller

This block sits on the host side of a serial analog-to-digital converter whose output needs a few clocks to start and carries a null bit. It runs from the system clock. A pulse on `start` makes it pull chip select low and produce a data clock from a programmable divider. It captures the serial input on each rising data-clock edge and builds the 12-bit straight-binary result. Chip select returns high as soon as the last wanted bit is in, which lets the converter power down.

The first two rising edges after chip select falls only turn on the converter's output. The third edge carries the null bit. Edges four to fifteen carry the word, most significant bit first. When `check_en` is high at start, the controller runs eleven more edges. On those edges the converter repeats bits 1 to 11 in reverse order, and the controller compares each one with the word already captured. Any difference sets `mismatch`. After each read, chip select stays high for one full data-clock period before another read can begin.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, and `busy`, `done`, `result` and `mismatch` are all zero.
- R2: A `start` seen while idle drives `cs_n` low on that clock. The data clock begins low. Each of its high and low phases lasts H system clocks, where H is `half_div`, or 1 when `half_div` is 0. A read with N rising edges therefore keeps `cs_n` low for exactly 2·N·H clocks and `sclk` high for N·H of them.
- R3: `sclk` is never high while `cs_n` is high.
- R4: Rising edges 1 and 2 (output enable) and 3 (null bit) are discarded. Edges 4 to 15 carry bits 11 down to 0, and that word is presented on `result`.
- R5: With `check_en` low at start the read has exactly 15 rising edges. With it high the read has exactly 26.
- R6: On edges 16 to 26 the serial input carries bits 1 to 11 in that order. With checking on, `mismatch` is set at `done` if any of these bits differs from the captured word. It reads 0 after a check-off read and is cleared on the clock that accepts a new start.
- R7: `cs_n` rises on the same clock as the falling `sclk` that follows the last rising edge. `done` is high for exactly that one clock.
- R8: `result` changes only on the clock where `done` is high, and holds its value through the next read until that read's `done`.
- R9: `busy` is high from an accepted start until the end of the guard interval. A `start` while `busy` is high has no effect.
- R10: After `cs_n` rises, `busy` stays high for 2·H clocks. With `start` held high, `cs_n` is high for exactly 2·H+1 clocks between two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one read; taken only when idle |
| check_en | input | 1 | Also read and compare the reversed repeat of the word |
| half_div | input | 8 | Data-clock half period in system clocks (0 is treated as 1) |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Data clock to the converter, idle low |
| busy | output | 1 | Read or guard interval in progress |
| done | output | 1 | One-clock pulse when a read completes |
| result | output | 12 | Last captured word, straight binary |
| mismatch | output | 1 | Reversed repeat disagreed with the word on the last read |

## Verification
The assertions check, on every clock, that the data clock stays low while chip select is high and that chip select is low only while busy. They also check that `done` is a single-clock pulse that coincides with chip select rising, and that `result` changes only with `done`. Other properties can only be shown by the bench's scenarios with a converter model, because they depend on what the converter sends: that the enable edges and the null bit are skipped, the edge counts in each mode, the phase lengths for several divider settings, detection of a corrupted repeat bit at both ends of the repeat, the exact guard length, and that `start` has no effect during a read and during the guard.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int WORD_W    = 12,
  parameter int EN_CLKS   = 2,
  parameter int NULL_BITS = 1,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              check_en,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              sdi,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              mismatch
);
  localparam int CW = $clog2(EN_CLKS + NULL_BITS + 2*WORD_W);
  localparam int IW = $clog2(WORD_W);
  localparam logic [CW-1:0] E_FIRST = CW'(EN_CLKS + NULL_BITS + 1);
  localparam logic [CW-1:0] E_WORD  = CW'(EN_CLKS + NULL_BITS + WORD_W);
  localparam logic [CW-1:0] E_MIRR  = CW'(EN_CLKS + NULL_BITS + 2*WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GUARD} st_t;
  st_t st;

  logic [DIV_W-1:0]  hp, ph;
  logic [DIV_W:0]    gc;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sh;
  logic              chk, err;

  wire           phase_end = (ph == hp - DIV_W'(1));
  wire [CW-1:0]  edge_n    = cnt + CW'(1);
  wire [IW-1:0]  mi        = IW'(edge_n - E_WORD);
  wire [CW-1:0]  last_edge = chk ? E_MIRR : E_WORD;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_n <= 1'b1; sclk <= 1'b0; done <= 1'b0;
      result <= '0; mismatch <= 1'b0; hp <= DIV_W'(1); ph <= '0;
      gc <= '0; cnt <= '0; sh <= '0; chk <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; cs_n <= 1'b0; ph <= '0; cnt <= '0;
          hp <= (half_div == '0) ? DIV_W'(1) : half_div;
          chk <= check_en; err <= 1'b0; mismatch <= 1'b0;
        end
        S_RUN: if (!phase_end) ph <= ph + DIV_W'(1);
        else begin
          ph <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            cnt  <= edge_n;
            if (edge_n >= E_FIRST && edge_n <= E_WORD) sh <= {sh[WORD_W-2:0], sdi};
            else if (edge_n > E_WORD && sdi != sh[mi]) err <= 1'b1;
          end else begin
            sclk <= 1'b0;
            if (cnt == last_edge) begin
              cs_n <= 1'b1; done <= 1'b1; result <= sh; mismatch <= err;
              st <= S_GUARD; gc <= '0;
            end
          end
        end
        S_GUARD: if (gc == {hp, 1'b0} - (DIV_W+1)'(1)) st <= S_IDLE;
                 else gc <= gc + (DIV_W+1)'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_cs_busy_r9:   assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  p_done_one_r7:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_cs_rise_r7:   assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(cs_n));
  p_res_hold_r8:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
endmodule

// File: tb/sim_adc_serial_reader.sv
module sim_adc_serial_reader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, check_en = 1'b0, sdi = 1'b1;
  logic [7:0] half_div = 8'd2;
  logic cs_n, sclk, busy, done, mismatch;
  logic [11:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_reader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .check_en(check_en),
    .half_div(half_div), .sdi(sdi), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .done(done), .result(result), .mismatch(mismatch)
  );

  int total = 0, fails = 0;
  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: changes output on falling data-clock edges
  logic [11:0] sw = '0;
  int bad = -1, fcnt = 0;
  always @(negedge cs_n) begin fcnt = 0; sdi = 1'b1; end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    fcnt++;
    if (fcnt < 2) sdi = 1'b1;
    else if (fcnt == 2) sdi = 1'b0;
    else if (fcnt <= 14) sdi = sw[14-fcnt];
    else if (fcnt <= 25) sdi = sw[fcnt-14] ^ ((fcnt-14) == bad);
    else sdi = 1'b0;
  end

  bit mon = 0;
  int lowcyc, hicyc, redges;
  always @(negedge clk) if (mon) begin
    if (!cs_n) lowcyc++;
    if (!cs_n && sclk) hicyc++;
  end
  always @(posedge sclk) if (mon && cs_n === 1'b0) redges++;

  logic [11:0] got_res;
  int got_mm, got_done, done_tail;

  task automatic launch(input logic [11:0] w, input bit c, input int bd, input int hd);
    while (busy) @(negedge clk);
    @(negedge clk);
    sw = w; bad = bd; check_en = c; half_div = 8'(hd);
    lowcyc = 0; hicyc = 0; redges = 0; mon = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_rd();
    got_done = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin got_done = 1; break; end
    end
    got_res = result; got_mm = int'(mismatch); mon = 0;
    @(negedge clk);
    done_tail = int'(done);
    check("R7 done seen", got_done, 1);
  endtask

  task automatic t_reset();
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    check("R1 mismatch", int'(mismatch), 0);
  endtask

  task automatic t_basic(input logic [11:0] w, input int hd);
    int h;
    h = (hd == 0) ? 1 : hd;
    launch(w, 0, -1, hd);
    finish_rd();
    check("R4 result", int'(got_res), int'(w));
    check("R5 edges check off", redges, 15);
    check("R2 cs low clocks", lowcyc, 30*h);
    check("R2 sclk high clocks", hicyc, 15*h);
    check("R7 done one clock", done_tail, 0);
    check("R6 mismatch check off", got_mm, 0);
  endtask

  task automatic t_mirror(input int bd);
    launch(12'h3E7, 1, bd, 2);
    finish_rd();
    check("R5 edges check on", redges, 26);
    check("R4 result with check", int'(got_res), 12'h3E7);
    check("R6 mismatch flag", got_mm, (bd > 0) ? 1 : 0);
  endtask

  task automatic t_bad_unchecked();
    launch(12'h123, 0, 5, 2);
    finish_rd();
    check("R6 corrupt repeat ignored when off", got_mm, 0);
    check("R5 edges check off", redges, 15);
  endtask

  task automatic t_clear_and_hold();
    launch(12'h456, 1, -1, 2);
    repeat (10) @(negedge clk);
    check("R6 mismatch cleared at start", int'(mismatch), 0);
    check("R8 result held during read", int'(result), 12'h3E7);
    finish_rd();
    check("R8 result updated at done", int'(got_res), 12'h456);
  endtask

  task automatic t_busy_ignore();
    int lows, dones;
    launch(12'h2B1, 0, -1, 2);
    repeat (10) @(negedge clk);
    start = 1'b1; check_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_rd();
    check("R9 start in read ignored edges", redges, 15);
    check("R9 start in read ignored result", int'(got_res), 12'h2B1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lows = 0; dones = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cs_n) lows++;
      if (done) dones++;
    end
    check("R9 start in guard ignored cs", lows, 0);
    check("R9 start in guard ignored done", dones, 0);
  endtask

  task automatic t_guard();
    int high;
    while (busy) @(negedge clk);
    @(negedge clk);
    sw = 12'h5A3; bad = -1; check_en = 1'b0; half_div = 8'd2; start = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    high = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cs_n) high++; else break;
    end
    start = 1'b0;
    check("R10 guard length", high, 5);
    mon = 1; redges = 0; lowcyc = 0; hicyc = 0;
    finish_rd();
    check("R10 second read result", int'(got_res), 12'h5A3);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; total++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic(12'hA5C, 3);
    t_basic(12'h000, 1);
    t_basic(12'hFFF, 0);
    t_mirror(-1);
    t_mirror(1);
    t_mirror(11);
    t_clear_and_hold();
    t_bad_unchecked();
    t_busy_ignore();
    t_guard();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule